// File: doc/BRIEF.md
# Text Window Raster Timer for an On-Screen Character Overlay

This block follows the raster of a video frame from a horizontal sync pulse, a vertical sync pulse and a dot-clock enable. It decides when a text window of 24 columns by 10 rows of 8×8-dot cells is on screen. For every displayed dot it gives the display-memory address of the character cell and the row and column of that dot inside the 8×8 font glyph. A downstream font lookup and video mixer take these outputs. Neither of them is part of this block.

Software-held registers outside the block give two 6-bit start values. The window starts vertically after twice the vertical value in lines, counted by horizontal sync pulses since vertical sync. It starts horizontally after twice the horizontal value in dot periods, counted by dot enables since horizontal sync. Each dot of the glyph may take one or two lines, and one or two dot periods. The topmost text row has its own pair of size bits, and all other rows share a second pair.

The memory address runs one dot ahead of the dot and window outputs. When the first dot of a cell is shown, its character code has already been addressed for a full dot period.

Top module: `osd_grid_timer`

## Requirements
- R1: While rst_n is low, and until the first sync pulse or dot enable afterwards, win_active, ram_addr, dot_row and dot_col are all 0.
- R2: Let L be the number of hsync_pulse cycles since the last vsync_pulse (the stretch before the first hsync is L=0). Line L is inside the vertical window exactly when 2·vstart ≤ L < 2·vstart + H0 + 9·HR. Here H0 = 8 lines for text row 0 (16 lines if vdbl_first=1), and HR = 8 lines for each of rows 1 to 9 (16 lines if vdbl_rest=1).
- R3: Let N be the number of counted dot enables since the last hsync_pulse, starting at 0. Dot N is inside the horizontal window exactly when 2·hstart ≤ N < 2·hstart + 24·8·m, where m is the horizontal size of the current line's text row.
- R4: Inside the window, dot_row and dot_col each run 0 to 7 within a cell. The column index runs 0 to 23 across the line and the row index runs 0 to 9 down the frame. win_active is 1 only when a dot lies inside both windows. Once column 23 or row 9 has finished, the index stays at 23 or 9 and ram_addr never exceeds 239.
- R5: The vertical size is m_v=2 (each dot row lasts 2 lines) when the size bit selected for the row is 1, and m_v=1 when it is 0. vdbl_first applies to row 0 and vdbl_rest to rows 1 to 9. dot_row = (line offset within the row) / m_v.
- R6: The horizontal size is m=2 (each dot column lasts 2 dot periods) when the size bit selected for the current line's text row is 1, and m=1 when it is 0. hdbl_first applies when that row is 0, including the lines above the window. hdbl_rest applies to rows 1 to 9, including the lines below the window. dot_col = (dot offset within the cell) / m.
- R7: After a counted dot N, ram_addr = row·24 + col, where row is the current line's text row and col is the column index of dot N+1. The column index is 0 before the horizontal window and 23 after it. The row index is 0 before the vertical window and 9 after it.
- R8: All outputs are registered. win_active, dot_row and dot_col describe dot N from the clock edge at which dot_en is sampled high until the next event. Cycles with no dot enable and no sync pulse leave every output unchanged.
- R9: An hsync_pulse restarts the horizontal count. On the next edge win_active and dot_col become 0, ram_addr becomes row(L)·24 for the new line L, and dot_row becomes that line's dot row. A dot_en high in the same cycle as hsync_pulse is not counted.
- R10: A vsync_pulse restarts both counts and takes priority over an hsync_pulse and a dot_en in the same cycle. On the next edge ram_addr, win_active, dot_row and dot_col are all 0, and the following line is L=0.
- R11: Outside the vertical window dot_row is 0, and outside the horizontal window dot_col is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_pulse | input | 1 | One-cycle pulse at the start of each line |
| vsync_pulse | input | 1 | One-cycle pulse at the start of each frame |
| dot_en | input | 1 | Dot-clock enable, one cycle per dot period |
| vstart | input | 6 | Vertical start, in units of two lines |
| hstart | input | 6 | Horizontal start, in units of two dot periods |
| vdbl_first | input | 1 | Row 0 uses two lines per dot row |
| vdbl_rest | input | 1 | Rows 1 to 9 use two lines per dot row |
| hdbl_first | input | 1 | Row 0 uses two dot periods per dot column |
| hdbl_rest | input | 1 | Rows 1 to 9 use two dot periods per dot column |
| win_active | output | 1 | Current dot lies inside the text window |
| ram_addr | output | 8 | Display-memory address of the next dot's cell |
| dot_row | output | 3 | Glyph row of the current dot |
| dot_col | output | 3 | Glyph column of the current dot |

## Verification
Two collisions are exercised. In the first, hsync_pulse and dot_en fall in the same cycle. The line must advance while the dot is dropped, so the next counted dot must be treated as dot 0 of the new line, and the scoreboard predicts it on that basis. In the second, vsync_pulse and hsync_pulse fall in the same cycle. The bench expects the frame restart to win, so it checks for address 0 and for the following dots to be modelled as line 0 rather than line 1. Both collisions are placed at points where the two outcomes give different ram_addr and dot values, so a wrong priority shows as a mismatch.

// File: rtl/osd_grid_pkg.sv
package osd_grid_pkg;

   // Position of one raster axis relative to the text window
   typedef enum logic [1:0] {
      PH_WAIT = 2'd0,   // before the start offset has elapsed
      PH_ACT  = 2'd1,   // inside the window
      PH_DONE = 2'd2    // last cell finished
   } axis_phase_t;

   localparam int unsigned GLYPH_DOTS = 8;

endpackage

// File: rtl/osd_axis_seq.sv
// One raster axis: start offset wait, then cells of GLYPH_DOTS dots,
// each dot lasting one or two steps. Also presents its next state.
module osd_axis_seq
   import osd_grid_pkg::*;
#(
   parameter int unsigned N_CELLS = 24,
   parameter int unsigned START_W = 6,
   parameter int unsigned DOT_W   = 3,
   parameter int unsigned CELL_W  = $clog2(N_CELLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              step,
   input  logic [START_W-1:0] start_val,
   input  logic              mag2,
   output logic              cur_act,
   output logic [CELL_W-1:0] cur_cell,
   output logic [DOT_W-1:0]  cur_dot,
   output logic              nxt_act,
   output logic [CELL_W-1:0] nxt_cell,
   output logic [DOT_W-1:0]  nxt_dot
);

   localparam int unsigned WAIT_W = START_W + 1;
   localparam logic [CELL_W-1:0] LAST_CELL = CELL_W'(N_CELLS - 1);
   localparam logic [DOT_W-1:0]  LAST_DOT  = DOT_W'((1 << DOT_W) - 1);

   generate
      if (N_CELLS < 2) begin : g_bad_cells
         $error("osd_axis_seq: N_CELLS must be at least 2");
      end
      if ((1 << DOT_W) != GLYPH_DOTS) begin : g_bad_dot
         $error("osd_axis_seq: DOT_W must address GLYPH_DOTS dots");
      end
      if ((1 << CELL_W) < N_CELLS) begin : g_bad_cellw
         $error("osd_axis_seq: CELL_W too narrow for N_CELLS");
      end
   endgenerate

   axis_phase_t       phase_q, phase_d;
   logic [WAIT_W-1:0] wcnt_q, wcnt_d;
   logic              sub_q, sub_d;
   logic [DOT_W-1:0]  dot_q, dot_d;
   logic [CELL_W-1:0] cell_q, cell_d;
   logic [WAIT_W-1:0] start_units;

   assign start_units = {start_val, 1'b0};

   always_comb begin
      phase_d = phase_q;
      wcnt_d  = wcnt_q;
      sub_d   = sub_q;
      dot_d   = dot_q;
      cell_d  = cell_q;
      if (restart) begin
         wcnt_d  = '0;
         sub_d   = 1'b0;
         dot_d   = '0;
         cell_d  = '0;
         phase_d = (start_val == '0) ? PH_ACT : PH_WAIT;
      end else if (step) begin
         unique case (phase_q)
            PH_WAIT: begin
               if (wcnt_q + WAIT_W'(1) == start_units) begin
                  phase_d = PH_ACT;
                  wcnt_d  = '0;
               end else begin
                  wcnt_d = wcnt_q + WAIT_W'(1);
               end
            end
            PH_ACT: begin
               if (mag2 && !sub_q) begin
                  sub_d = 1'b1;
               end else begin
                  sub_d = 1'b0;
                  if (dot_q == LAST_DOT) begin
                     dot_d = '0;
                     if (cell_q == LAST_CELL) begin
                        phase_d = PH_DONE;
                     end else begin
                        cell_d = cell_q + CELL_W'(1);
                     end
                  end else begin
                     dot_d = dot_q + DOT_W'(1);
                  end
               end
            end
            default: begin
               phase_d = PH_DONE;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_WAIT;
         wcnt_q  <= '0;
         sub_q   <= 1'b0;
         dot_q   <= '0;
         cell_q  <= '0;
      end else begin
         phase_q <= phase_d;
         wcnt_q  <= wcnt_d;
         sub_q   <= sub_d;
         dot_q   <= dot_d;
         cell_q  <= cell_d;
      end
   end

   assign cur_act  = (phase_q == PH_ACT);
   assign cur_cell = cell_q;
   assign cur_dot  = dot_q;
   assign nxt_act  = (phase_d == PH_ACT);
   assign nxt_cell = cell_d;
   assign nxt_dot  = dot_d;

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_ACT) |-> (dot_q == '0 && !sub_q)); // R11

   AST_CELL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cell_q <= LAST_CELL); // R4

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DONE && !restart) |=> (phase_q == PH_DONE)); // R4

   AST_RESTART_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cell_q == '0 && dot_q == '0)); // R10

endmodule

// File: rtl/osd_pix_reg.sv
// Output register stage: window flag, glyph position and the lookahead
// display-memory address. Sync pulses take priority over dot enables.
module osd_pix_reg #(
   parameter int unsigned N_COLS = 24,
   parameter int unsigned N_ROWS = 10,
   parameter int unsigned DOT_W  = 3,
   parameter int unsigned COL_W  = $clog2(N_COLS),
   parameter int unsigned ROW_W  = $clog2(N_ROWS),
   parameter int unsigned ADDR_W = $clog2(N_COLS * N_ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vsync,
   input  logic              hsync,
   input  logic              dot_en,
   input  logic              v_cur_act,
   input  logic [ROW_W-1:0]  v_cur_cell,
   input  logic [DOT_W-1:0]  v_cur_dot,
   input  logic [ROW_W-1:0]  v_nxt_cell,
   input  logic [DOT_W-1:0]  v_nxt_dot,
   input  logic              h_cur_act,
   input  logic [DOT_W-1:0]  h_cur_dot,
   input  logic [COL_W-1:0]  h_nxt_cell,
   output logic              win,
   output logic [ADDR_W-1:0] addr,
   output logic [DOT_W-1:0]  drow,
   output logic [DOT_W-1:0]  dcol
);

   localparam int unsigned CELLS = N_COLS * N_ROWS;

   generate
      if ((1 << ADDR_W) < CELLS) begin : g_bad_addr
         $error("osd_pix_reg: ADDR_W too narrow for the grid");
      end
   endgenerate

   logic [ADDR_W-1:0] line_base;
   logic [ADDR_W-1:0] next_line_base;
   logic [ADDR_W-1:0] dot_addr;

   assign line_base      = ADDR_W'(v_cur_cell) * ADDR_W'(N_COLS);
   assign next_line_base = ADDR_W'(v_nxt_cell) * ADDR_W'(N_COLS);
   assign dot_addr       = line_base + ADDR_W'(h_nxt_cell);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win  <= 1'b0;
         addr <= '0;
         drow <= '0;
         dcol <= '0;
      end else if (vsync) begin
         win  <= 1'b0;
         addr <= '0;
         drow <= '0;
         dcol <= '0;
      end else if (hsync) begin
         win  <= 1'b0;
         addr <= next_line_base;
         drow <= v_nxt_dot;
         dcol <= '0;
      end else if (dot_en) begin
         win  <= v_cur_act && h_cur_act;
         addr <= dot_addr;
         drow <= v_cur_dot;
         dcol <= h_cur_dot;
      end
   end

   AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!dot_en && !hsync && !vsync) |=> ($stable(win) && $stable(addr))); // R8

   AST_HS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      hsync |=> (!win && dcol == '0)); // R9

   AST_VS_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |=> (addr == '0 && drow == '0)); // R10

   AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(addr) < int'(CELLS)); // R4

endmodule

// File: rtl/osd_grid_timer.sv
module osd_grid_timer #(
   parameter int unsigned N_COLS  = 24,
   parameter int unsigned N_ROWS  = 10,
   parameter int unsigned START_W = 6,
   parameter int unsigned DOT_W   = 3,
   parameter int unsigned ADDR_W  = $clog2(N_COLS * N_ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsync_pulse,
   input  logic              vsync_pulse,
   input  logic              dot_en,
   input  logic [START_W-1:0] vstart,
   input  logic [START_W-1:0] hstart,
   input  logic              vdbl_first,
   input  logic              vdbl_rest,
   input  logic              hdbl_first,
   input  logic              hdbl_rest,
   output logic              win_active,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DOT_W-1:0]  dot_row,
   output logic [DOT_W-1:0]  dot_col
);

   localparam int unsigned COL_W = $clog2(N_COLS);
   localparam int unsigned ROW_W = $clog2(N_ROWS);

   generate
      if (START_W < 1) begin : g_bad_start
         $error("osd_grid_timer: START_W must be at least 1");
      end
   endgenerate

   logic              v_restart, v_step, h_restart, h_step;
   logic              v_cur_act, v_nxt_act, h_cur_act, h_nxt_act;
   logic [ROW_W-1:0]  v_cur_cell, v_nxt_cell;
   logic [COL_W-1:0]  h_cur_cell, h_nxt_cell;
   logic [DOT_W-1:0]  v_cur_dot, v_nxt_dot, h_cur_dot, h_nxt_dot;
   logic              top_row;
   logic              v_mag2, h_mag2;

   // vsync beats hsync; any sync beats a dot enable in the same cycle
   assign v_restart = vsync_pulse;
   assign v_step    = hsync_pulse && !vsync_pulse;
   assign h_restart = hsync_pulse || vsync_pulse;
   assign h_step    = dot_en && !h_restart;

   assign top_row = (v_cur_cell == '0);
   assign v_mag2  = top_row ? vdbl_first : vdbl_rest;
   assign h_mag2  = top_row ? hdbl_first : hdbl_rest;

   osd_axis_seq #(
      .N_CELLS (N_ROWS),
      .START_W (START_W),
      .DOT_W   (DOT_W),
      .CELL_W  (ROW_W)
   ) u_vseq (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (v_restart),
      .step      (v_step),
      .start_val (vstart),
      .mag2      (v_mag2),
      .cur_act   (v_cur_act),
      .cur_cell  (v_cur_cell),
      .cur_dot   (v_cur_dot),
      .nxt_act   (v_nxt_act),
      .nxt_cell  (v_nxt_cell),
      .nxt_dot   (v_nxt_dot)
   );

   osd_axis_seq #(
      .N_CELLS (N_COLS),
      .START_W (START_W),
      .DOT_W   (DOT_W),
      .CELL_W  (COL_W)
   ) u_hseq (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (h_restart),
      .step      (h_step),
      .start_val (hstart),
      .mag2      (h_mag2),
      .cur_act   (h_cur_act),
      .cur_cell  (h_cur_cell),
      .cur_dot   (h_cur_dot),
      .nxt_act   (h_nxt_act),
      .nxt_cell  (h_nxt_cell),
      .nxt_dot   (h_nxt_dot)
   );

   osd_pix_reg #(
      .N_COLS (N_COLS),
      .N_ROWS (N_ROWS),
      .DOT_W  (DOT_W),
      .COL_W  (COL_W),
      .ROW_W  (ROW_W),
      .ADDR_W (ADDR_W)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .vsync      (vsync_pulse),
      .hsync      (hsync_pulse),
      .dot_en     (dot_en),
      .v_cur_act  (v_cur_act),
      .v_cur_cell (v_cur_cell),
      .v_cur_dot  (v_cur_dot),
      .v_nxt_cell (v_nxt_cell),
      .v_nxt_dot  (v_nxt_dot),
      .h_cur_act  (h_cur_act),
      .h_cur_dot  (h_cur_dot),
      .h_nxt_cell (h_nxt_cell),
      .win        (win_active),
      .addr       (ram_addr),
      .drow       (dot_row),
      .dcol       (dot_col)
   );

   AST_WIN_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (dot_en && !hsync_pulse && !vsync_pulse && !(v_cur_act && h_cur_act))
      |=> !win_active); // R4

   AST_ROW_SAME_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (dot_en && !hsync_pulse && !vsync_pulse) |=> $stable(dot_row)); // R5

   logic unused_ok;
   assign unused_ok = ^{v_nxt_act, h_nxt_act, h_cur_cell, h_nxt_dot};

endmodule

// File: tb/osd_grid_timer_tb.sv
module osd_grid_timer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hsync_pulse = 1'b0;
   logic       vsync_pulse = 1'b0;
   logic       dot_en = 1'b0;
   logic [5:0] vstart = '0;
   logic [5:0] hstart = '0;
   logic       vdbl_first = 1'b0;
   logic       vdbl_rest = 1'b0;
   logic       hdbl_first = 1'b0;
   logic       hdbl_rest = 1'b0;
   logic       win_active;
   logic [7:0] ram_addr;
   logic [2:0] dot_row;
   logic [2:0] dot_col;

   always #2.5 clk = ~clk;

   osd_grid_timer u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .hsync_pulse (hsync_pulse),
      .vsync_pulse (vsync_pulse),
      .dot_en      (dot_en),
      .vstart      (vstart),
      .hstart      (hstart),
      .vdbl_first  (vdbl_first),
      .vdbl_rest   (vdbl_rest),
      .hdbl_first  (hdbl_first),
      .hdbl_rest   (hdbl_rest),
      .win_active  (win_active),
      .ram_addr    (ram_addr),
      .dot_row     (dot_row),
      .dot_col     (dot_col)
   );

   int errors = 0;
   int checks = 0;
   int cur_line = 0;
   int cur_dot = 0;

   typedef struct {
      int win;
      int addr;
      int drow;
      int dcol;
   } exp_t;
   exp_t sbq[$];
   exp_t last_exp;
   logic pend = 1'b0;

   task automatic chk(input int act, input int exp, input string lbl);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", lbl, act, exp);
      end
   endtask

   // Vertical reference: act, row index, dot row for line l
   function automatic void vref(input int l, output int act, output int row, output int drow);
      int vs, h0, hr, off;
      int m0, mr;
      m0 = vdbl_first ? 2 : 1;
      mr = vdbl_rest ? 2 : 1;
      vs = 2 * int'(vstart);
      h0 = 8 * m0;
      hr = 8 * mr;
      act = 0; row = 0; drow = 0;
      if (l >= vs) begin
         off = l - vs;
         if (off < h0) begin
            act = 1; row = 0; drow = off / m0;
         end else if (off - h0 < 9 * hr) begin
            off = off - h0;
            act = 1; row = 1 + off / hr; drow = (off % hr) / mr;
         end else begin
            row = 9;
         end
      end
   endfunction

   // Horizontal reference for dot n at horizontal size m
   function automatic void href(input int n, input int m, output int act, output int col, output int dcol);
      int hs, w, off;
      hs = 2 * int'(hstart);
      w = 8 * m;
      act = 0; col = 0; dcol = 0;
      if (n >= hs) begin
         off = n - hs;
         if (off < 24 * w) begin
            act = 1; col = off / w; dcol = (off % w) / m;
         end else begin
            col = 23;
         end
      end
   endfunction

   function automatic exp_t predict(input int l, input int n);
      exp_t e;
      int va, row, drow, ha, col, dcol, na, ncol, nd, m;
      vref(l, va, row, drow);
      m = (row == 0) ? (hdbl_first ? 2 : 1) : (hdbl_rest ? 2 : 1);
      href(n, m, ha, col, dcol);
      href(n + 1, m, na, ncol, nd);
      e.win = (va != 0 && ha != 0) ? 1 : 0;
      e.addr = row * 24 + ncol;
      e.drow = drow;
      e.dcol = dcol;
      return e;
   endfunction

   // Monitor: a counted dot at a posedge is compared at the next negedge
   always @(posedge clk) pend <= rst_n && dot_en && !hsync_pulse && !vsync_pulse;

   initial begin
      forever begin
         @(negedge clk);
         if (pend) begin
            if (sbq.size() == 0) begin
               chk(1, 0, "R8 unexpected output event");
            end else begin
               exp_t e;
               e = sbq.pop_front();
               chk(int'(win_active), e.win, "R2 R3 R4 win_active");
               chk(int'(ram_addr), e.addr, "R7 ram_addr lookahead");
               chk(int'(dot_row), e.drow, "R5 R11 dot_row");
               chk(int'(dot_col), e.dcol, "R6 R11 dot_col");
            end
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_vsync(input bit with_hs);
      vsync_pulse = 1'b1;
      hsync_pulse = with_hs;
      dot_en = with_hs;
      tick();
      vsync_pulse = 1'b0;
      hsync_pulse = 1'b0;
      dot_en = 1'b0;
      cur_line = 0;
      cur_dot = 0;
      chk(int'(ram_addr), 0, "R10 vsync address home");
      chk(int'(win_active), 0, "R10 vsync window off");
      chk(int'(dot_row), 0, "R10 vsync dot_row");
   endtask

   task automatic do_hsync(input bit with_dot);
      int va, row, drow;
      hsync_pulse = 1'b1;
      dot_en = with_dot;
      tick();
      hsync_pulse = 1'b0;
      dot_en = 1'b0;
      cur_line++;
      cur_dot = 0;
      vref(cur_line, va, row, drow);
      chk(int'(win_active), 0, "R9 hsync window off");
      chk(int'(ram_addr), row * 24, "R9 hsync line base address");
      chk(int'(dot_row), drow, "R9 hsync dot_row");
      chk(int'(dot_col), 0, "R9 hsync dot_col");
   endtask

   task automatic do_dots(input int n, input bit gap);
      for (int i = 0; i < n; i++) begin
         last_exp = predict(cur_line, cur_dot);
         sbq.push_back(last_exp);
         dot_en = 1'b1;
         tick();
         dot_en = 1'b0;
         cur_dot++;
         if (gap) begin
            tick();
            chk(int'(win_active), last_exp.win, "R8 hold win_active");
            chk(int'(ram_addr), last_exp.addr, "R8 hold ram_addr");
         end
      end
   endtask

   task automatic run_frame(input int lines, input int dots, input bit gap);
      do_vsync(1'b0);
      do_dots(dots, gap);
      for (int l = 0; l < lines; l++) begin
         do_hsync(1'b0);
         do_dots(dots, gap);
      end
   endtask

   task automatic set_cfg(input int vp, input int hp, input bit v0, input bit vr,
                          input bit h0, input bit hr);
      vstart = 6'(vp);
      hstart = 6'(hp);
      vdbl_first = v0;
      vdbl_rest = vr;
      hdbl_first = h0;
      hdbl_rest = hr;
   endtask

   task automatic finish_run();
      repeat (3) tick();
      chk(sbq.size(), 0, "R8 scoreboard drained");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R8 watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) tick();
      // R1: reset state
      chk(int'(win_active), 0, "R1 reset win_active");
      chk(int'(ram_addr), 0, "R1 reset ram_addr");
      chk(int'(dot_row), 0, "R1 reset dot_row");
      chk(int'(dot_col), 0, "R1 reset dot_col");
      rst_n = 1'b1;
      tick();
      chk(int'(ram_addr), 0, "R1 after release ram_addr");

      // R2 R3 R4 R7: offsets, single size, whole grid and past the end
      set_cfg(1, 2, 1'b0, 1'b0, 1'b0, 1'b0);
      run_frame(84, 199, 1'b0);

      // R5 R6: doubled top row, single rest, zero offsets, right edge of row 0
      set_cfg(0, 0, 1'b1, 1'b0, 1'b1, 1'b0);
      run_frame(90, 386, 1'b0);

      // R5 R6 R8: single top row, doubled rest, gapped dot enables
      set_cfg(5, 3, 1'b0, 1'b1, 1'b0, 1'b1);
      run_frame(164, 60, 1'b1);

      // R9 R10: collisions of hsync with dot_en and vsync with hsync
      set_cfg(0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
      do_vsync(1'b0);
      do_dots(20, 1'b0);
      do_hsync(1'b1);
      do_dots(20, 1'b0);
      do_hsync(1'b0);
      do_dots(13, 1'b0);
      do_hsync(1'b1);
      do_dots(30, 1'b0);
      for (int l = 0; l < 9; l++) begin
         do_hsync(1'b0);
         do_dots(12, 1'b0);
      end
      do_vsync(1'b1);
      do_dots(25, 1'b0);
      do_hsync(1'b0);
      do_dots(25, 1'b0);

      finish_run();
   end

endmodule